// File: doc/BRIEF.md
# Edge-Triggered Pin Interrupt Line Controller

This block turns a set of general-purpose input pins into per-line interrupt requests. There are sixteen lines, and the ports are a group of pin banks of equal width. Line n listens to pin n of one port, chosen by a 4-bit port-select field. Every pin passes through a two-flop synchronizer. After the port multiplexer, each line compares its synchronized level with its previous level to find rising and falling edges.

Each line has separate rising and falling trigger enables. A selected edge sets a sticky pending bit. Software clears that bit only by writing 1 to it. The interrupt request for a line is its pending bit gated by a per-line unmask bit.

A small word-addressed register port configures the block and reads its state. Reads are combinational. Writes take effect at the clock edge where the write enable is high.

Top module: `pin_irq_ctrl`

## Requirements
- R1: Line n takes pin n of the port selected by its 4-bit field. Port p, pin n is `port_pins_i[p*16+n]`. The field for line n sits in selector word n/4 at bits 4*(n mod 4)+3 down to 4*(n mod 4). Code 0 is port 0, code 1 is port 1, and so on. A code equal to or above NUM_PORTS selects a constant 0.
- R2: Every pin is synchronized through two flops before edge detection. Suppose a pin changes before a clock edge and the change forms an enabled, unmasked edge. Then `irq_o` rises after the third clock edge counted from that change, and not earlier.
- R3: If a line's bit in the rising-enable register (index 1) is 1, a 0-to-1 transition on the line sets its pending bit. If that bit is 0, a rising transition does not set pending.
- R4: If a line's bit in the falling-enable register (index 2) is 1, a 1-to-0 transition sets pending. If that bit is 0, a falling transition does not set pending. With both enables set, either direction sets pending.
- R5: A pending bit stays set until software writes 1 to it in the pending register (index 3). Writing 0 to a pending bit leaves it unchanged.
- R6: If an enabled edge and a write-one clear hit the same line in the same cycle, the pending bit stays set.
- R7: `irq_o[n]` equals pending bit n AND unmask bit n (mask register, index 0, 1 = unmasked). An edge on a masked line still sets its pending bit. Unmasking the line then raises `irq_o[n]` right after the unmask write.
- R8: Writing a line's selector field does not by itself create an edge. The edge history is reloaded from the newly selected synchronized input.
- R9: Register indices are 0 mask, 1 rising-enable, 2 falling-enable, 3 pending, and 4 to 7 selector words 0 to 3. Each register reads back its current value, and all are zero after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_pins_i | input | NUM_PORTS*NUM_LINES | Raw pin levels; port p pin n at bit p*NUM_LINES+n |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Register write index |
| wr_data_i | input | DATA_W | Register write data |
| rd_addr_i | input | ADDR_W | Register read index |
| rd_data_o | output | DATA_W | Register read data (combinational) |
| irq_o | output | NUM_LINES | Per-line interrupt requests |

## Verification
Directed sequences drive isolated rising and falling transitions with each trigger enable on and off. These separate the rising path from the falling path and show that a disabled direction is ignored. One case lands a clear write on the exact cycle the third synchronizer edge arrives, to show that the set wins. Other cases toggle a masked line and then unmask it, and switch selectors between ports that hold different levels or to invalid codes. Together they separate a real pin edge from a selector-induced step. A long random phase of pin toggles and register writes is then compared every cycle against a behavioural model, checking both request outputs and read data.

// File: rtl/pin_irq_pkg.sv
package pin_irq_pkg;
  localparam int SEL_W           = 4;
  localparam int FIELDS_PER_WORD = 4;
  localparam int IDX_MASK        = 0;
  localparam int IDX_RISE        = 1;
  localparam int IDX_FALL        = 2;
  localparam int IDX_PEND        = 3;
  localparam int IDX_SEL_BASE    = 4;
endpackage

// File: rtl/pin_irq_sync.sv
module pin_irq_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage1_q, stage2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage1_q <= '0;
      stage2_q <= '0;
    end else begin
      stage1_q <= d_i;
      stage2_q <= stage1_q;
    end
  end

  assign q_o = stage2_q;
endmodule

// File: rtl/pin_irq_regs.sv
module pin_irq_regs
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 3
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              wr_en_i,
  input  logic [ADDR_W-1:0]                 wr_addr_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic [ADDR_W-1:0]                 rd_addr_i,
  input  logic [NUM_LINES-1:0]              pend_i,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic [NUM_LINES-1:0]              mask_o,
  output logic [NUM_LINES-1:0]              rise_o,
  output logic [NUM_LINES-1:0]              fall_o,
  output logic [NUM_LINES-1:0][SEL_W-1:0]   sel_o,
  output logic [NUM_LINES-1:0][SEL_W-1:0]   sel_new_o,
  output logic [NUM_LINES-1:0]              sel_load_o,
  output logic [NUM_LINES-1:0]              pend_clr_o
);
  localparam int SEL_WORDS = (NUM_LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD;

  logic [NUM_LINES-1:0]            mask_q, rise_q, fall_q;
  logic [NUM_LINES-1:0][SEL_W-1:0] sel_q;
  logic [SEL_WORDS-1:0][DATA_W-1:0] sel_word;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int idx);
    return a == ADDR_W'(idx);
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
    end else if (wr_en_i) begin
      if (hit(wr_addr_i, IDX_MASK)) mask_q <= wr_data_i[NUM_LINES-1:0];
      if (hit(wr_addr_i, IDX_RISE)) rise_q <= wr_data_i[NUM_LINES-1:0];
      if (hit(wr_addr_i, IDX_FALL)) fall_q <= wr_data_i[NUM_LINES-1:0];
    end
  end

  assign pend_clr_o = (wr_en_i && hit(wr_addr_i, IDX_PEND)) ? wr_data_i[NUM_LINES-1:0] : '0;

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_sel
    localparam int WORD = n / FIELDS_PER_WORD;
    localparam int POS  = SEL_W * (n % FIELDS_PER_WORD);
    assign sel_new_o[n]  = wr_data_i[POS +: SEL_W];
    assign sel_load_o[n] = wr_en_i && hit(wr_addr_i, IDX_SEL_BASE + WORD);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            sel_q[n] <= '0;
      else if (sel_load_o[n]) sel_q[n] <= sel_new_o[n];
    end
  end

  always_comb begin
    sel_word = '0;
    for (int n = 0; n < NUM_LINES; n++)
      sel_word[n / FIELDS_PER_WORD][SEL_W * (n % FIELDS_PER_WORD) +: SEL_W] = sel_q[n];
  end

  always_comb begin
    rd_data_o = '0;
    if (hit(rd_addr_i, IDX_MASK)) rd_data_o[NUM_LINES-1:0] = mask_q;
    if (hit(rd_addr_i, IDX_RISE)) rd_data_o[NUM_LINES-1:0] = rise_q;
    if (hit(rd_addr_i, IDX_FALL)) rd_data_o[NUM_LINES-1:0] = fall_q;
    if (hit(rd_addr_i, IDX_PEND)) rd_data_o[NUM_LINES-1:0] = pend_i;
    for (int k = 0; k < SEL_WORDS; k++)
      if (hit(rd_addr_i, IDX_SEL_BASE + k)) rd_data_o = sel_word[k];
  end

  assign mask_o = mask_q;
  assign rise_o = rise_q;
  assign fall_o = fall_q;
  assign sel_o  = sel_q;

  assert_mask_write_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && hit(wr_addr_i, IDX_MASK)) |=> mask_o == $past(wr_data_i[NUM_LINES-1:0]));
endmodule

// File: rtl/pin_irq_line.sv
module pin_irq_line
  import pin_irq_pkg::*;
#(
  parameter int NUM_PORTS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] pins_i,
  input  logic [SEL_W-1:0]     sel_i,
  input  logic [SEL_W-1:0]     sel_new_i,
  input  logic                 sel_load_i,
  input  logic                 rise_en_i,
  input  logic                 fall_en_i,
  input  logic                 clr_i,
  output logic                 pend_o
);
  logic cur, reload_val, prev_q, pend_q, edge_hit;

  function automatic logic pick(input logic [NUM_PORTS-1:0] v, input logic [SEL_W-1:0] s);
    logic r;
    r = 1'b0;
    for (int p = 0; p < NUM_PORTS; p++)
      if (s == SEL_W'(p)) r = v[p];
    return r;
  endfunction

  assign cur        = pick(pins_i, sel_i);
  assign reload_val = pick(pins_i, sel_new_i);
  assign edge_hit   = (rise_en_i & cur & ~prev_q) | (fall_en_i & ~cur & prev_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      // selector write: restart history from the new input
      prev_q <= sel_load_i ? reload_val : cur;
      pend_q <= (pend_q & ~clr_i) | edge_hit;
    end
  end

  assign pend_o = pend_q;

  assert_edge_sets_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_hit |=> pend_q);
  assert_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!edge_hit && !clr_i) |=> pend_q == $past(pend_q));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !edge_hit) |=> !pend_q);
  assert_set_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pend_q) |-> $past(edge_hit));
endmodule

// File: rtl/pin_irq_ctrl.sv
module pin_irq_ctrl
  import pin_irq_pkg::*;
#(
  parameter int NUM_LINES = 16,
  parameter int NUM_PORTS = 8,
  parameter int DATA_W    = 32,
  localparam int SEL_WORDS = (NUM_LINES + FIELDS_PER_WORD - 1) / FIELDS_PER_WORD,
  localparam int ADDR_W    = $clog2(IDX_SEL_BASE + SEL_WORDS),
  localparam int PIN_W     = NUM_PORTS * NUM_LINES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [PIN_W-1:0]     port_pins_i,
  input  logic                 wr_en_i,
  input  logic [ADDR_W-1:0]    wr_addr_i,
  input  logic [DATA_W-1:0]    wr_data_i,
  input  logic [ADDR_W-1:0]    rd_addr_i,
  output logic [DATA_W-1:0]    rd_data_o,
  output logic [NUM_LINES-1:0] irq_o
);
  logic [PIN_W-1:0]                pins_sync;
  logic [NUM_LINES-1:0]            mask, rise, fall, pend, sel_load, pend_clr;
  logic [NUM_LINES-1:0][SEL_W-1:0] sel, sel_new;

  pin_irq_sync #(.WIDTH(PIN_W)) u_sync (
    .clk_i, .rst_ni, .d_i(port_pins_i), .q_o(pins_sync)
  );

  pin_irq_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .rd_addr_i,
    .pend_i(pend), .rd_data_o, .mask_o(mask), .rise_o(rise), .fall_o(fall),
    .sel_o(sel), .sel_new_o(sel_new), .sel_load_o(sel_load), .pend_clr_o(pend_clr)
  );

  for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
    logic [NUM_PORTS-1:0] line_pins;
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign line_pins[p] = pins_sync[p*NUM_LINES + n];
    end
    pin_irq_line #(.NUM_PORTS(NUM_PORTS)) u_line (
      .clk_i, .rst_ni, .pins_i(line_pins), .sel_i(sel[n]), .sel_new_i(sel_new[n]),
      .sel_load_i(sel_load[n]), .rise_en_i(rise[n]), .fall_en_i(fall[n]),
      .clr_i(pend_clr[n]), .pend_o(pend[n])
    );
  end

  assign irq_o = pend & mask;
endmodule

// File: tb/pin_irq_ctrl_test.sv
`timescale 1ns/1ps
module pin_irq_ctrl_test;
  localparam int NL = 16, NP = 8, DW = 32, AW = 3, PW = NL*NP;

  logic clk = 0, rst_ni = 0;
  logic [PW-1:0] pins = '0;
  logic wr_en = 0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [DW-1:0] rd_data;
  logic [NL-1:0] irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pin_irq_ctrl uut (
    .clk_i(clk), .rst_ni(rst_ni), .port_pins_i(pins), .wr_en_i(wr_en),
    .wr_addr_i(wr_addr), .wr_data_i(wr_data), .rd_addr_i(rd_addr),
    .rd_data_o(rd_data), .irq_o(irq)
  );

  // behavioural reference model
  logic [PW-1:0] m_s1, m_s2;
  logic [NL-1:0] m_prev, m_pend, m_mask, m_rise, m_fall;
  logic [3:0]    m_sel [NL];

  function automatic logic m_pick(input logic [PW-1:0] v, input int n, input logic [3:0] s);
    if (int'(s) >= NP) return 1'b0;
    return v[int'(s)*NL + n];
  endfunction

  function automatic logic [DW-1:0] m_read(input logic [AW-1:0] a);
    logic [DW-1:0] r;
    r = '0;
    case (int'(a))
      0: r[NL-1:0] = m_mask;
      1: r[NL-1:0] = m_rise;
      2: r[NL-1:0] = m_fall;
      3: r[NL-1:0] = m_pend;
      default: for (int j = 0; j < 4; j++) r[4*j +: 4] = m_sel[(int'(a)-4)*4 + j];
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_s1 = '0; m_s2 = '0; m_prev = '0; m_pend = '0;
      m_mask = '0; m_rise = '0; m_fall = '0;
      for (int n = 0; n < NL; n++) m_sel[n] = '0;
    end else begin
      logic [NL-1:0] cur, e, clr;
      for (int n = 0; n < NL; n++) cur[n] = m_pick(m_s2, n, m_sel[n]);
      e = (cur & ~m_prev & m_rise) | (~cur & m_prev & m_fall);
      clr = (wr_en && wr_addr == 3) ? wr_data[NL-1:0] : '0;
      m_pend = (m_pend & ~clr) | e;
      m_prev = cur;
      if (wr_en) begin
        case (int'(wr_addr))
          0: m_mask = wr_data[NL-1:0];
          1: m_rise = wr_data[NL-1:0];
          2: m_fall = wr_data[NL-1:0];
          3: ;
          default: for (int j = 0; j < 4; j++) begin
            int n;
            n = (int'(wr_addr)-4)*4 + j;
            m_sel[n] = wr_data[4*j +: 4];
            m_prev[n] = m_pick(m_s2, n, m_sel[n]);
          end
        endcase
      end
      m_s2 = m_s1;
      m_s1 = pins;
    end
  end

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(posedge clk) begin
    #3;
    if (rst_ni && !done) begin
      chk("R7 irq vs model", DW'(irq), DW'(m_pend & m_mask));
      chk("R9 read vs model", rd_data, m_read(rd_addr));
    end
  end

  task automatic wr(input int a, input logic [DW-1:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] d);
    rd_addr = AW'(a);
    #1 d = rd_data;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    // R9 reset state
    for (int a = 0; a < 8; a++) begin
      rd(a, v);
      chk("R9 reset value", v, '0);
    end
    chk("R7 reset irq", DW'(irq), '0);

    // R1 / R3 / R2: line 2 from port 2 (code 2, word 0 bits 11:8)
    wr(4, 32'h0000_0200);
    wr(1, 32'h4);
    wr(0, 32'h4);
    pins[2] = 1'b1;                      // port 0 pin 2: not selected
    repeat (4) @(negedge clk);
    chk("R1 unselected port ignored", DW'(irq[2]), 0);
    pins[2*NL+2] = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2 no irq after two edges", DW'(irq[2]), 0);
    @(negedge clk);
    chk("R2 irq after third edge", DW'(irq[2]), 1);

    // R5 write-zero keeps, write-one clears
    wr(3, 32'h0);
    rd(3, v);
    chk("R5 write 0 keeps pending", DW'(v[2]), 1);
    wr(3, 32'h4);
    rd(3, v);
    chk("R5 write 1 clears pending", DW'(v[2]), 0);

    // R4 falling disabled, then enabled
    pins[2*NL+2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 falling ignored when disabled", DW'(irq[2]), 0);
    wr(2, 32'h4);
    pins[2*NL+2] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 rising with both enables", DW'(irq[2]), 1);
    wr(3, 32'h4);
    pins[2*NL+2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R4 falling sets pending", DW'(irq[2]), 1);
    wr(3, 32'h4);
    wr(1, 32'h0);
    pins[2*NL+2] = 1'b1;
    repeat (4) @(negedge clk);
    chk("R3 rising ignored when disabled", DW'(irq[2]), 0);
    wr(1, 32'h4);
    pins[2*NL+2] = 1'b0;
    repeat (4) @(negedge clk);
    wr(3, 32'h4);

    // R6 edge and clear in the same cycle
    pins[2*NL+2] = 1'b1;
    repeat (2) @(negedge clk);
    wr_en = 1; wr_addr = 3'd3; wr_data = 32'h4;
    @(negedge clk);
    wr_en = 0;
    rd(3, v);
    chk("R6 edge beats clear", DW'(v[2]), 1);
    wr(3, 32'h4);

    // R7 masked edge latches, unmask raises irq
    wr(0, 32'h0);
    pins[2*NL+2] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R7 masked line no irq", DW'(irq[2]), 0);
    rd(3, v);
    chk("R7 masked edge pending", DW'(v[2]), 1);
    wr(0, 32'h4);
    chk("R7 unmask raises irq", DW'(irq[2]), 1);
    wr(3, 32'h4);

    // R8 selector change between differing levels
    wr(1, 32'h24); wr(2, 32'h24); wr(0, 32'h24);
    pins[1*NL+5] = 1'b1;
    repeat (4) @(negedge clk);
    wr(5, 32'h10);                        // line 5 -> port 1
    repeat (5) @(negedge clk);
    chk("R8 selector switch no edge", DW'(irq[5]), 0);
    pins[1*NL+5] = 1'b0;
    repeat (4) @(negedge clk);
    chk("R1 new port edge seen", DW'(irq[5]), 1);
    wr(3, 32'h20);

    // R1 invalid code yields constant 0
    pins[5] = 1'b1; pins[1*NL+5] = 1'b1;
    wr(5, 32'h90);
    repeat (5) @(negedge clk);
    chk("R1 invalid code constant 0", DW'(irq[5]), 0);
    rd(5, v);
    chk("R9 selector readback", v, 32'h90);

    // random phase, checked by the model each cycle
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      wr_en = 0;
      if ($urandom % 3 == 0) pins[$urandom % PW] ^= 1'b1;
      rd_addr = AW'($urandom);
      if ($urandom % 6 == 0) begin
        wr_en = 1;
        wr_addr = AW'($urandom);
        wr_data = $urandom;
      end
    end
    @(negedge clk);
    wr_en = 0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule